// File: doc/BRIEF.md
# Banked Register File Addressing Unit

This block sits between the instruction decoder of a small 8-bit microcontroller core and its data storage. It takes the 5-bit register operand of an instruction, the current bank number and the indirect pointer. From these it works out which physical location the instruction touches, returns the byte held there, and applies a write when strobed. Register operand 0 never names storage of its own: it is an alias. Any access to it is sent through the pointer register, so software can walk tables.

In every bank the low eight operand values name shared special slots. Slot 0 is the alias and slot 1 is the pointer. Slots 2 to 7 are external registers owned by neighbouring logic: the timer value, the low byte of the program counter, the status byte and three I/O ports. Reads of these slots come from `ext_rd_data`, and writes raise a one-cycle strobe in `ext_we`. Operand values 8 to 31 are general storage, kept separately for each bank.

The block also holds three kinds of control state that no register address reaches. These are the bank number, three port direction latches and an option byte, and each is loaded by its own dedicated operation. The parameter `ENHANCED` picks the addressing variant. With it set, eight banks of storage exist and the bank number forms the top three address bits. With it cleared there is a single bank, and the bank load is ignored.

Top module: `bank_file_unit`

## Requirements
- R1: With `field_sel` not 0, `phys_addr` equals `{bank, field_sel}` (8 bits) when `ENHANCED`=1 and equals `field_sel` (5 bits) when `ENHANCED`=0. General slots with the same operand value in different banks are distinct bytes.
- R2: With `field_sel` = 0, `phys_addr` equals the pointer, cut to the width of `phys_addr`. Reads and writes act on the location that address names, decoded by the same rules as a direct access.
- R3: If an access through the alias lands on a physical address whose low 5 bits are 0, the read returns 0 and the write changes no state and raises no `ext_we` bit.
- R4: The low 5 bits of the resolved address select the target in every bank. Value 1 is the pointer, which can be read and written. Values 2..7 are external slot k = value-2 (0 timer, 1 program counter low byte, 2 status, 3..5 ports 0..2). A read of slot k returns `ext_rd_data[8k+7:8k]`, and a write raises only `ext_we[k]`. Values 8..31 are general storage.
- R5: A write takes effect on the rising clock edge when `wr_en` is high, using `wr_data`. `rd_data` follows the resolved address with no clock delay while `rd_en` is high and is 0 while `rd_en` is low. `ext_we` is 0 while `wr_en` is low.
- R6: When `ENHANCED`=1, `bank_ld` loads the bank number from `bank_imm` at the clock edge. When `ENHANCED`=0, `bank_ld` has no effect on `phys_addr`.
- R7: `dir_ld` copies `wreg` into port direction latch `dir_sel` (0..2) at the clock edge, and `dir_sel` = 3 changes nothing. Latch p drives `dir_q[8p+7:8p]`, where bit value 1 means input and 0 means output. No register write changes `dir_q`.
- R8: `opt_ld` copies `wreg` into `opt_q` at the clock edge. No register write changes `opt_q`.
- R9: While `rst_n` is low, the pointer and the bank number are 0, all general storage is 0, every direction bit is 1 and `opt_q` is 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| field_sel | input | 5 | Register operand from the instruction |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Byte to write to the resolved location |
| bank_ld | input | 1 | Load bank number from bank_imm |
| bank_imm | input | 3 | Immediate bank number |
| wreg | input | 8 | Working register value for dedicated loads |
| dir_ld | input | 1 | Load a port direction latch from wreg |
| dir_sel | input | 2 | Port direction latch to load |
| opt_ld | input | 1 | Load option byte from wreg |
| ext_rd_data | input | 48 | Current values of the six external slots, slot k in byte k |
| phys_addr | output | 8 (5 when ENHANCED=0) | Resolved physical address |
| rd_data | output | 8 | Read byte |
| ext_we | output | 6 | Write strobe for each external slot |
| dir_q | output | 24 | Port direction latches, port p in byte p |
| opt_q | output | 8 | Option byte |

## Verification
The assertions assume two things about the inputs: every input is a known value after reset, and the operand and strobes stay steady from the falling edge to the next rising edge. The hold properties for the pointer, bank, direction and option state also assume that only the dedicated load or a mapped write can change that state. To respect both, the bench drives every input at the falling edge and compares outputs 2 ns later. It runs two instances at once, one per addressing variant, against a behavioural model indexed by full physical address. Directed steps cover the alias, self-reference, bank switching and ignored loads, and a random phase follows them.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  localparam int unsigned FIELD_W     = 5;
  localparam int unsigned DATA_W      = 8;
  localparam int unsigned BANK_W      = 3;
  localparam int unsigned ALIAS_OFS   = 0;
  localparam int unsigned PTR_OFS     = 1;
  localparam int unsigned EXT_BASE    = 2;
  localparam int unsigned NUM_EXT     = 6;
  localparam int unsigned GP_BASE     = EXT_BASE + NUM_EXT;
  localparam int unsigned SLOTS       = 1 << FIELD_W;
  localparam int unsigned GP_PER_BANK = SLOTS - GP_BASE;

  // What the low operand bits of a resolved address select
  typedef enum logic [1:0] {
    TGT_VOID,   // alias seen through itself
    TGT_PTR,
    TGT_EXT,
    TGT_GP
  } tgt_e;
endpackage

// File: rtl/bfu_resolve.sv
module bfu_resolve
  import bfu_pkg::*;
#(
  parameter bit ENHANCED  = 1'b1,
  parameter int ADDR_W    = 8,
  parameter int GP_IDX_W  = 8,
  parameter int EXT_IDX_W = 3
) (
  input  logic [FIELD_W-1:0]   field,
  input  logic [BANK_W-1:0]    bank,
  input  logic [DATA_W-1:0]    ptr,
  output logic [ADDR_W-1:0]    eff_addr,
  output tgt_e                 tgt,
  output logic [EXT_IDX_W-1:0] ext_idx,
  output logic [GP_IDX_W-1:0]  gp_idx
);
  logic [ADDR_W-1:0]  direct_addr;
  logic [ADDR_W-1:0]  ptr_addr;
  logic [BANK_W-1:0]  eff_bank;
  logic [FIELD_W-1:0] low;
  logic               via_ptr;

  generate
    if (ENHANCED) begin : g_banked
      assign direct_addr = {bank, field};
      assign ptr_addr    = ptr[ADDR_W-1:0];
      assign eff_bank    = eff_addr[ADDR_W-1:FIELD_W];
    end else begin : g_flat
      logic unused_hi;
      assign unused_hi   = ^{bank, ptr[DATA_W-1:ADDR_W]};
      assign direct_addr = field;
      assign ptr_addr    = ptr[ADDR_W-1:0];
      assign eff_bank    = '0;
    end
  endgenerate

  assign via_ptr  = (field == FIELD_W'(ALIAS_OFS));
  assign eff_addr = via_ptr ? ptr_addr : direct_addr;
  assign low      = eff_addr[FIELD_W-1:0];

  always_comb begin
    if (low == FIELD_W'(ALIAS_OFS))      tgt = TGT_VOID;
    else if (low == FIELD_W'(PTR_OFS))   tgt = TGT_PTR;
    else if (low < FIELD_W'(GP_BASE))    tgt = TGT_EXT;
    else                                 tgt = TGT_GP;
  end

  assign ext_idx = EXT_IDX_W'(low - FIELD_W'(EXT_BASE));
  assign gp_idx  = GP_IDX_W'(int'(eff_bank) * int'(GP_PER_BANK)
                             + int'(low) - int'(GP_BASE));
endmodule

// File: rtl/bfu_ctrl.sv
module bfu_ctrl
  import bfu_pkg::*;
#(
  parameter bit ENHANCED  = 1'b1,
  parameter int NUM_PORTS = 3,
  parameter int DSEL_W    = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ptr_we,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          bank_ld,
  input  logic [BANK_W-1:0]             bank_imm,
  input  logic [DATA_W-1:0]             wreg,
  input  logic                          dir_ld,
  input  logic [DSEL_W-1:0]             dir_sel,
  input  logic                          opt_ld,
  output logic [DATA_W-1:0]             ptr_q,
  output logic [BANK_W-1:0]             bank_q,
  output logic [NUM_PORTS*DATA_W-1:0]   dir_q,
  output logic [DATA_W-1:0]             opt_q
);
  logic [DATA_W-1:0]           ptr_nxt;
  logic [NUM_PORTS*DATA_W-1:0] dir_nxt;
  logic [DATA_W-1:0]           opt_nxt;

  // Next-state
  assign ptr_nxt = wr_data;
  assign opt_nxt = wreg;

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dir
      assign dir_nxt[p*DATA_W +: DATA_W] =
        (dir_sel == DSEL_W'(p)) ? wreg : dir_q[p*DATA_W +: DATA_W];
    end
  endgenerate

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (ptr_we)  ptr_q <= ptr_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dir_q <= '1;
    else if (dir_ld)  dir_q <= dir_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       opt_q <= '1;
    else if (opt_ld)  opt_q <= opt_nxt;
  end

  generate
    if (ENHANCED) begin : g_bank
      logic [BANK_W-1:0] bank_nxt;
      assign bank_nxt = bank_imm;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        bank_q <= '0;
        else if (bank_ld)  bank_q <= bank_nxt;
      end

      AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_ld |=> $stable(bank_q)); // R6
    end else begin : g_nobank
      logic unused_bank;
      assign unused_bank = ^{bank_ld, bank_imm};
      assign bank_q      = '0;
    end
  endgenerate

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_we |=> $stable(ptr_q)); // R4
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_ld |=> $stable(dir_q)); // R7
  AST_OPT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !opt_ld |=> $stable(opt_q)); // R8
endmodule

// File: rtl/bfu_store.sv
module bfu_store
  import bfu_pkg::*;
#(
  parameter int DEPTH = 192,
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_q
);
  logic [DATA_W-1:0] mem_q   [DEPTH];
  logic [DATA_W-1:0] mem_nxt [DEPTH];
  logic              in_range;

  assign in_range = (32'(idx) < 32'(DEPTH));

  always_comb begin
    mem_nxt = mem_q;
    if (in_range) mem_nxt[idx] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q <= mem_nxt;
    end
  end

  assign rd_q = in_range ? mem_q[idx] : '0;
endmodule

// File: rtl/bank_file_unit.sv
module bank_file_unit
  import bfu_pkg::*;
#(
  parameter bit ENHANCED  = 1'b1,
  parameter int NUM_PORTS = 3,
  parameter int DSEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  parameter int ADDR_W    = ENHANCED ? (BANK_W + FIELD_W) : FIELD_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [FIELD_W-1:0]          field_sel,
  input  logic                        rd_en,
  input  logic                        wr_en,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        bank_ld,
  input  logic [BANK_W-1:0]           bank_imm,
  input  logic [DATA_W-1:0]           wreg,
  input  logic                        dir_ld,
  input  logic [DSEL_W-1:0]           dir_sel,
  input  logic                        opt_ld,
  input  logic [NUM_EXT*DATA_W-1:0]   ext_rd_data,
  output logic [ADDR_W-1:0]           phys_addr,
  output logic [DATA_W-1:0]           rd_data,
  output logic [NUM_EXT-1:0]          ext_we,
  output logic [NUM_PORTS*DATA_W-1:0] dir_q,
  output logic [DATA_W-1:0]           opt_q
);
  localparam int NBANKS    = ENHANCED ? (1 << BANK_W) : 1;
  localparam int GP_DEPTH  = NBANKS * GP_PER_BANK;
  localparam int GP_IDX_W  = $clog2(GP_DEPTH);
  localparam int EXT_IDX_W = $clog2(NUM_EXT);

  tgt_e                 tgt;
  logic [EXT_IDX_W-1:0] ext_idx;
  logic [GP_IDX_W-1:0]  gp_idx;
  logic [DATA_W-1:0]    ptr_q;
  logic [BANK_W-1:0]    bank_q;
  logic [DATA_W-1:0]    gp_rd;
  logic [DATA_W-1:0]    ext_sel;
  logic [DATA_W-1:0]    sel_val;
  logic                 ptr_we;
  logic                 gp_we;

  bfu_resolve #(
    .ENHANCED (ENHANCED),
    .ADDR_W   (ADDR_W),
    .GP_IDX_W (GP_IDX_W),
    .EXT_IDX_W(EXT_IDX_W)
  ) i_resolve (
    .field   (field_sel),
    .bank    (bank_q),
    .ptr     (ptr_q),
    .eff_addr(phys_addr),
    .tgt     (tgt),
    .ext_idx (ext_idx),
    .gp_idx  (gp_idx)
  );

  assign ptr_we = wr_en && (tgt == TGT_PTR);
  assign gp_we  = wr_en && (tgt == TGT_GP);

  bfu_ctrl #(
    .ENHANCED (ENHANCED),
    .NUM_PORTS(NUM_PORTS),
    .DSEL_W   (DSEL_W)
  ) i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ptr_we  (ptr_we),
    .wr_data (wr_data),
    .bank_ld (bank_ld),
    .bank_imm(bank_imm),
    .wreg    (wreg),
    .dir_ld  (dir_ld),
    .dir_sel (dir_sel),
    .opt_ld  (opt_ld),
    .ptr_q   (ptr_q),
    .bank_q  (bank_q),
    .dir_q   (dir_q),
    .opt_q   (opt_q)
  );

  bfu_store #(
    .DEPTH(GP_DEPTH),
    .IDX_W(GP_IDX_W)
  ) i_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (gp_we),
    .idx    (gp_idx),
    .wr_data(wr_data),
    .rd_q   (gp_rd)
  );

  // External slot read select and write strobes
  always_comb begin
    ext_sel = '0;
    for (int k = 0; k < NUM_EXT; k++) begin
      if (ext_idx == EXT_IDX_W'(k)) ext_sel = ext_rd_data[k*DATA_W +: DATA_W];
    end
  end

  generate
    for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext_we
      assign ext_we[k] = wr_en && (tgt == TGT_EXT) && (ext_idx == EXT_IDX_W'(k));
    end
  endgenerate

  always_comb begin
    unique case (tgt)
      TGT_VOID: sel_val = '0;
      TGT_PTR:  sel_val = ptr_q;
      TGT_EXT:  sel_val = ext_sel;
      default:  sel_val = gp_rd;
    endcase
  end

  assign rd_data = rd_en ? sel_val : '0;

  AST_EXT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ext_we)); // R4
  AST_EXT_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (ext_we == '0)); // R5
  AST_DIRECT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (field_sel != '0) |-> (phys_addr[FIELD_W-1:0] == field_sel)); // R1
  AST_SELF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && field_sel == '0 && ptr_q[FIELD_W-1:0] == '0) |-> (rd_data == '0)); // R3
  AST_SELF_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (field_sel == '0 && ptr_q[FIELD_W-1:0] == '0) |-> (ext_we == '0)); // R3
endmodule

// File: tb/test_bank_file_unit.sv
`timescale 1ns/1ps
module test_bank_file_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  field_sel;
  logic        rd_en, wr_en;
  logic [7:0]  wr_data;
  logic        bank_ld;
  logic [2:0]  bank_imm;
  logic [7:0]  wreg;
  logic        dir_ld;
  logic [1:0]  dir_sel;
  logic        opt_ld;
  logic [47:0] ext_rd_data;

  logic [7:0]  phys_e, rd_e, opt_e;
  logic [5:0]  we_e;
  logic [23:0] dir_e;
  logic [4:0]  phys_s;
  logic [7:0]  rd_s, opt_s;
  logic [5:0]  we_s;
  logic [23:0] dir_s;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // model state, index 0 = flat variant, 1 = banked variant
  int mem_m [2][256];
  int ptr_m [2];
  int bank_m [2];
  int dir_m [2][3];
  int opt_m [2];

  always #5 clk = ~clk;

  bank_file_unit #(.ENHANCED(1'b1)) i_bank_file_unit (
    .clk(clk), .rst_n(rst_n), .field_sel(field_sel), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .bank_ld(bank_ld), .bank_imm(bank_imm), .wreg(wreg),
    .dir_ld(dir_ld), .dir_sel(dir_sel), .opt_ld(opt_ld), .ext_rd_data(ext_rd_data),
    .phys_addr(phys_e), .rd_data(rd_e), .ext_we(we_e), .dir_q(dir_e), .opt_q(opt_e));

  bank_file_unit #(.ENHANCED(1'b0)) i_bank_file_unit_std (
    .clk(clk), .rst_n(rst_n), .field_sel(field_sel), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .bank_ld(bank_ld), .bank_imm(bank_imm), .wreg(wreg),
    .dir_ld(dir_ld), .dir_sel(dir_sel), .opt_ld(opt_ld), .ext_rd_data(ext_rd_data),
    .phys_addr(phys_s), .rd_data(rd_s), .ext_we(we_s), .dir_q(dir_s), .opt_q(opt_s));

  task automatic chk(input string tag, input string what, input int m,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s (variant %0d): actual %h expected %h", tag, what, m, got, exp);
    end
  endtask

  function automatic string pick(input string tag, input string dflt);
    return (tag == "R9" || tag == "R6") ? tag : dflt;
  endfunction

  function automatic int eff(input int m, input int f, input int bnk, input int p);
    if (f == 0) return (m == 1) ? p : (p & 31);
    return (m == 1) ? ((bnk << 5) | f) : f;
  endfunction

  task automatic model_reset();
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 256; a++) mem_m[m][a] = 0;
      ptr_m[m] = 0; bank_m[m] = 0; opt_m[m] = 8'hFF;
      for (int p = 0; p < 3; p++) dir_m[m][p] = 8'hFF;
    end
  endtask

  task automatic compare(input string tag);
    for (int m = 0; m < 2; m++) begin
      int a, low, v, ew, dv;
      a   = eff(m, int'(field_sel), bank_m[m], ptr_m[m]);
      low = a & 31;
      if (low == 0)      v = 0;
      else if (low == 1) v = ptr_m[m];
      else if (low < 8)  v = int'(ext_rd_data[(low-2)*8 +: 8]);
      else               v = mem_m[m][a];
      ew = (wr_en && low >= 2 && low < 8) ? (1 << (low - 2)) : 0;
      dv = (dir_m[m][2] << 16) | (dir_m[m][1] << 8) | dir_m[m][0];
      chk(tag, "rd_data", m, (m == 1) ? 32'(rd_e) : 32'(rd_s), rd_en ? v : 0);
      chk(pick(tag, (field_sel == 0) ? "R2" : "R1"), "phys_addr", m,
          (m == 1) ? 32'(phys_e) : 32'(phys_s), a);
      chk(pick(tag, "R4"), "ext_we", m, (m == 1) ? 32'(we_e) : 32'(we_s), ew);
      chk(pick(tag, "R7"), "dir_q", m, (m == 1) ? 32'(dir_e) : 32'(dir_s), dv);
      chk(pick(tag, "R8"), "opt_q", m, (m == 1) ? 32'(opt_e) : 32'(opt_s), opt_m[m]);
    end
  endtask

  task automatic model_clock();
    for (int m = 0; m < 2; m++) begin
      int a, low;
      a   = eff(m, int'(field_sel), bank_m[m], ptr_m[m]);
      low = a & 31;
      if (wr_en) begin
        if (low == 1)      ptr_m[m] = int'(wr_data);
        else if (low >= 8) mem_m[m][a] = int'(wr_data);
      end
      if (bank_ld && m == 1) bank_m[m] = int'(bank_imm);
      if (dir_ld && dir_sel < 3) dir_m[m][dir_sel] = int'(wreg);
      if (opt_ld) opt_m[m] = int'(wreg);
    end
  endtask

  task automatic step(input string tag, input int f, input bit re, input bit we,
                      input int wd, input bit bl = 0, input int bi = 0,
                      input bit dl = 0, input int ds = 0, input bit ol = 0,
                      input int wr = 0);
    @(negedge clk);
    field_sel = 5'(f); rd_en = re; wr_en = we; wr_data = 8'(wd);
    bank_ld = bl; bank_imm = 3'(bi); dir_ld = dl; dir_sel = 2'(ds);
    opt_ld = ol; wreg = 8'(wr);
    #2;
    compare(tag);
    @(posedge clk);
    #1;
    model_clock();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    field_sel = '0; rd_en = 0; wr_en = 0; wr_data = '0; bank_ld = 0; bank_imm = '0;
    wreg = '0; dir_ld = 0; dir_sel = '0; opt_ld = 0;
    ext_rd_data = 48'hA5A4A3A2A1A0;
    model_reset();
    repeat (3) @(negedge clk);
    #2;
    compare("R9");
    @(negedge clk);
    rst_n = 1'b1;

    // R9: state just after reset
    step("R9", 8, 1, 0, 0);
    step("R9", 1, 1, 0, 0);
    step("R9", 0, 1, 0, 0);
    // R5: writes land at the edge, reads are immediate and gated
    step("R5", 8, 1, 1, 8'h11);
    step("R5", 9, 1, 1, 8'h22);
    step("R5", 31, 1, 1, 8'h33);
    step("R5", 8, 1, 0, 0);
    step("R5", 31, 0, 0, 0);
    // R6: bank load, honoured only by the banked variant
    step("R6", 10, 1, 0, 0, 1, 5);
    step("R6", 10, 1, 1, 8'h55);
    step("R6", 10, 1, 0, 0);
    step("R1", 10, 1, 0, 0, 1, 0);
    step("R1", 10, 1, 0, 0);
    step("R1", 8, 1, 0, 0);
    // R2: access through the alias
    step("R2", 1, 1, 1, 8'hAA);
    step("R2", 0, 1, 0, 0);
    step("R2", 0, 1, 1, 8'h77);
    step("R2", 0, 1, 0, 0);
    step("R2", 10, 1, 0, 0, 1, 5);
    step("R2", 10, 1, 0, 0, 1, 0);
    // R3: alias pointing at itself, also from a higher bank
    step("R3", 1, 1, 1, 8'h20);
    step("R3", 0, 1, 0, 0);
    step("R3", 0, 1, 1, 8'h99);
    step("R3", 1, 1, 0, 0);
    step("R3", 1, 1, 1, 8'h00);
    step("R3", 0, 1, 1, 8'h5A);
    step("R3", 8, 1, 0, 0);
    // R4: external slots direct and via the alias
    for (int k = 2; k < 8; k++) step("R4", k, 1, 1, 8'hC0 + k);
    step("R4", 1, 1, 1, 8'h04);
    step("R4", 0, 1, 0, 0);
    step("R4", 0, 1, 1, 8'h3E);
    step("R4", 1, 1, 1, 8'h01);
    step("R4", 0, 1, 0, 0);
    // R7: direction latches, invalid select ignored, map cannot reach them
    step("R7", 2, 1, 0, 0, 0, 0, 1, 0, 0, 8'h0F);
    step("R7", 3, 1, 0, 0, 0, 0, 1, 1, 0, 8'hF0);
    step("R7", 4, 1, 0, 0, 0, 0, 1, 3, 0, 8'h00);
    step("R7", 5, 0, 1, 8'h00);
    step("R7", 6, 0, 1, 8'h00);
    step("R7", 7, 1, 0, 0, 0, 0, 1, 2, 0, 8'h81);
    // R8: option byte only through its own load
    step("R8", 9, 1, 0, 0, 0, 0, 0, 0, 1, 8'h3C);
    step("R8", 1, 1, 1, 8'h00);
    step("R8", 0, 1, 1, 8'h00);
    step("R8", 9, 1, 0, 0);

    // Random phase against the model
    void'($urandom(32'h1F3));
    for (int n = 0; n < 600; n++) begin
      if (n % 50 == 0) ext_rd_data = {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF;
      step("R5", int'($urandom_range(0, 31)), bit'($urandom_range(0, 1)),
           bit'($urandom_range(0, 1)), int'($urandom_range(0, 255)),
           ($urandom_range(0, 7) == 0), int'($urandom_range(0, 7)),
           ($urandom_range(0, 7) == 0), int'($urandom_range(0, 3)),
           ($urandom_range(0, 7) == 0), int'($urandom_range(0, 255)));
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule